// File: doc/BRIEF.md
# Packet Client Control and Status Registers

This block is the register file of an Ethernet packet-client test harness. It sits on a simple word-addressed bus with separate read and write strobes. Software uses it to steer the packet generator and the MAC loopback path, to read identification and build-time feature information, and to collect error conditions from the loopback FIFO.

The FIFO reports underflow and overflow as single-cycle pulses. The block turns these pulses into sticky status bits. The bits stay set until software writes a dedicated clear bit. That clear bit reads back as 1 for one cycle only, and then drops by itself. An error pulse that arrives in the same cycle as a clear is not lost.

The generator, the FIFO and the temperature sensor live elsewhere. Here they appear only as status inputs and control outputs. A read strobe returns data one clock later. All state resets synchronously on an active-high reset.

Top module: `pkt_client_csr`

## Requirements
- R1: Offset 0x1000 holds a 32-bit scratch word that resets to 0. A read returns the last value written to it.
- R2: Offset 0x1001 is read-only. It always reads 32'h434C4E54, which is the text "CLNT" with the first character in the most significant byte.
- R3: Offset 0x1002 is a read-only 10-bit feature word. Bit 0 is the device-family flag and bit 1 selects 100G (1) or 40G (0). Bit 2 selects the reference clock: 1 means 644 MHz and 0 means 322 MHz. Bits 3 to 7 report, in this order: KR4, CAUI-4, precision time protocol, pause and local fault. Bit 8 reads 0 and bit 9 reads 1. Bits 0 to 7 come from parameters, and the upper bits of the word read 0.
- R4: Offset 0x1010 is a 4-bit control register that resets to 4'b0101. Bit 1 drives `gen_off`, where 1 turns the generator off. Bit 3 drives `lpbk_mode`. Bits 0 and 2 read back as written and drive nothing.
- R5: An `fifo_unf` pulse sets bit 0 of offset 0x1015, and an `fifo_ovf` pulse sets bit 1. Each flag stays at 1 until it is cleared.
- R6: A write to 0x1015 with bit 2 at 1 clears both flags, unless a pulse for that flag arrives in the same cycle; in that case the flag stays set. Bit 2 reads 1 during the cycle after the clearing write and 0 after that. A write to bits 1:0 has no effect. The register resets to 0.
- R7: Offset 0x1016 bit 0 resets to 0. It reads back as written and drives `lpbk_rst`.
- R8: Offset 0x1006 returns the `temp_f` input in bits 7:0, with 0 in the upper bits.
- R9: A read of an offset that is not mapped returns 0. A write to an unmapped or read-only offset changes no readable state.
- R10: `rd_data` is registered. It carries the read result in the cycle after a cycle with `rd_en` high, and 0 after a cycle with `rd_en` low. When a read and a write hit the same offset in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| temp_f | input | 8 | Temperature reading |
| fifo_unf | input | 1 | Loopback FIFO underflow pulse |
| fifo_ovf | input | 1 | Loopback FIFO overflow pulse |
| gen_off | output | 1 | Packet generator disable |
| lpbk_mode | output | 1 | MAC loopback mode select |
| lpbk_rst | output | 1 | Loopback path reset |

## Verification
The assertions assume that the strobes, the address and the FIFO pulses hold known 0/1 values in every cycle after reset. They also assume that a FIFO pulse is a level sampled once per clock, which lets one pulse and one clear land in the same cycle. The stimulus changes every input only on the falling clock edge and holds it for whole cycles. It places an overflow pulse in the exact cycle of a clear write, so the rule that a pulse beats a clear is exercised. Every read result is predicted from the requirements and checked in the cycle after its strobe.

// File: rtl/pkt_client_csr.sv
module pkt_client_csr #(
  parameter int ADDR_W    = 16,
  parameter bit F_FAMILY  = 1'b1,
  parameter bit F_100G    = 1'b0,
  parameter bit F_REF644  = 1'b0,
  parameter bit F_KR4     = 1'b0,
  parameter bit F_CAUI4   = 1'b0,
  parameter bit F_PTP     = 1'b0,
  parameter bit F_PAUSE   = 1'b0,
  parameter bit F_LFAULT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [7:0]        temp_f,
  input  logic              fifo_unf,
  input  logic              fifo_ovf,
  output logic              gen_off,
  output logic              lpbk_mode,
  output logic              lpbk_rst
);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'('h1000);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'('h1001);
  localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'('h1002);
  localparam logic [ADDR_W-1:0] A_TEMP = ADDR_W'('h1006);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('h1010);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'('h1015);
  localparam logic [ADDR_W-1:0] A_LRST = ADDR_W'('h1016);
  localparam logic [31:0] ID_WORD = 32'h434C_4E54;
  localparam logic [3:0]  CTL_RST = 4'b0101;
  localparam logic [9:0]  FEAT_VEC = {1'b1, 1'b0, F_LFAULT, F_PAUSE, F_PTP,
                                      F_CAUI4, F_KR4, F_REF644, F_100G, F_FAMILY};

  logic [31:0] scratch;
  logic [3:0]  ctl;
  logic [1:0]  err_flags;
  logic        clr_pend;
  logic        lrst_q;
  logic [31:0] rd_mux;

  wire wr_scr  = wr_en && addr == A_SCR;
  wire wr_ctl  = wr_en && addr == A_CTL;
  wire wr_lrst = wr_en && addr == A_LRST;
  wire clr_now = wr_en && addr == A_ERR && wr_data[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch <= '0;
      ctl     <= CTL_RST;
      lrst_q  <= 1'b0;
    end else begin
      if (wr_scr)  scratch <= wr_data;
      if (wr_ctl)  ctl     <= wr_data[3:0];
      if (wr_lrst) lrst_q  <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      clr_pend  <= 1'b0;
    end else begin
      clr_pend     <= clr_now;
      err_flags[0] <= fifo_unf | (err_flags[0] & ~clr_now);
      err_flags[1] <= fifo_ovf | (err_flags[1] & ~clr_now);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_SCR:   rd_mux = scratch;
      A_ID:    rd_mux = ID_WORD;
      A_FEAT:  rd_mux[9:0] = FEAT_VEC;
      A_TEMP:  rd_mux[7:0] = temp_f;
      A_CTL:   rd_mux[3:0] = ctl;
      A_ERR:   rd_mux[2:0] = {clr_pend, err_flags};
      A_LRST:  rd_mux[0]   = lrst_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_en ? rd_mux : '0;
  end

  assign gen_off   = ctl[1];
  assign lpbk_mode = ctl[3];
  assign lpbk_rst  = lrst_q;
endmodule

module pkt_client_csr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              fifo_unf,
  input logic              fifo_ovf,
  input logic              gen_off,
  input logic              lpbk_mode,
  input logic              lpbk_rst,
  input logic [1:0]        err_flags,
  input logic              clr_pend
);
  wire hit_err = addr == ADDR_W'('h1015);
  wire clr_wr  = wr_en && hit_err && wr_data[2];
  wire mapped  = addr == ADDR_W'('h1000) || addr == ADDR_W'('h1001) ||
                 addr == ADDR_W'('h1002) || addr == ADDR_W'('h1006) ||
                 addr == ADDR_W'('h1010) || hit_err ||
                 addr == ADDR_W'('h1016);

  AST_UNF_SETS:   assert property (@(posedge clk) disable iff (rst) fifo_unf |=> err_flags[0]); // R5
  AST_OVF_SETS:   assert property (@(posedge clk) disable iff (rst) fifo_ovf |=> err_flags[1]); // R5
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst) err_flags[0] && !clr_wr |=> err_flags[0]); // R5
  AST_CLR_WORKS:  assert property (@(posedge clk) disable iff (rst) clr_wr && !fifo_unf |=> !err_flags[0]); // R6
  AST_CLR_SELF:   assert property (@(posedge clk) disable iff (rst) clr_pend && !clr_wr |=> !clr_pend); // R6
  AST_ID_CONST:   assert property (@(posedge clk) disable iff (rst) rd_en && addr == ADDR_W'('h1001) |=> rd_data == 32'h434C4E54); // R2
  AST_UNMAPPED:   assert property (@(posedge clk) disable iff (rst) rd_en && !mapped |=> rd_data == 32'h0); // R9
  AST_RD_IDLE:    assert property (@(posedge clk) disable iff (rst) !rd_en |=> rd_data == 32'h0); // R10
  AST_GEN_OFF:    assert property (@(posedge clk) disable iff (rst) wr_en && addr == ADDR_W'('h1010) |=> gen_off == $past(wr_data[1]) && lpbk_mode == $past(wr_data[3])); // R4
  AST_LRST_OUT:   assert property (@(posedge clk) disable iff (rst) wr_en && addr == ADDR_W'('h1016) |=> lpbk_rst == $past(wr_data[0])); // R7
endmodule

bind pkt_client_csr pkt_client_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .fifo_unf(fifo_unf), .fifo_ovf(fifo_ovf),
  .gen_off(gen_off), .lpbk_mode(lpbk_mode), .lpbk_rst(lpbk_rst),
  .err_flags(err_flags), .clr_pend(clr_pend)
);

// File: tb/pkt_client_csr_tb.sv
module pkt_client_csr_tb;
  localparam int AW = 16;
  localparam bit P_FAM = 1'b1, P_100G = 1'b1, P_REF = 1'b0, P_KR4 = 1'b0;
  localparam bit P_CAUI = 1'b1, P_PTP = 1'b0, P_PAUSE = 1'b1, P_LF = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0] temp_f = 8'h00;
  logic fifo_unf = 1'b0, fifo_ovf = 1'b0;
  logic gen_off, lpbk_mode, lpbk_rst;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  pkt_client_csr #(.ADDR_W(AW), .F_FAMILY(P_FAM), .F_100G(P_100G), .F_REF644(P_REF),
    .F_KR4(P_KR4), .F_CAUI4(P_CAUI), .F_PTP(P_PTP), .F_PAUSE(P_PAUSE), .F_LFAULT(P_LF)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .temp_f(temp_f), .fifo_unf(fifo_unf), .fifo_ovf(fifo_ovf),
    .gen_off(gen_off), .lpbk_mode(lpbk_mode), .lpbk_rst(lpbk_rst));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R10 unexpected read", rd_data, 32'hDEADBEEF);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R4 gen_off reset", {31'b0, gen_off}, 32'h0);
    check("R4 lpbk_mode reset", {31'b0, lpbk_mode}, 32'h0);
    check("R7 lpbk_rst reset", {31'b0, lpbk_rst}, 32'h0);
    check("R10 rd_data reset", rd_data, 32'h0);
    rd(16'h1010, 32'h5, "R4 ctl reset");
    rd(16'h1015, 32'h0, "R6 err reset");
    rd(16'h1016, 32'h0, "R7 lrst reset");
    rd(16'h1000, 32'h0, "R1 scratch reset");
    rd(16'h1001, 32'h434C4E54, "R2 id");
    rd(16'h1002, {22'b0, 1'b1, 1'b0, P_LF, P_PAUSE, P_PTP, P_CAUI, P_KR4, P_REF, P_100G, P_FAM}, "R3 feature");
    wr(16'h1000, 32'hA5A55A5A);
    rd(16'h1000, 32'hA5A55A5A, "R1 scratch pattern1");
    wr(16'h1000, 32'hFFFF0000);
    rd(16'h1000, 32'hFFFF0000, "R1 scratch pattern2");
    temp_f = 8'h9C;
    rd(16'h1006, 32'h9C, "R8 temp");
    wr(16'h1010, 32'hA);
    check("R4 gen_off set", {31'b0, gen_off}, 32'h1);
    check("R4 lpbk_mode set", {31'b0, lpbk_mode}, 32'h1);
    rd(16'h1010, 32'hA, "R4 ctl readback");
    wr(16'h1010, 32'hFFFFFFF4);
    check("R4 gen_off clear", {31'b0, gen_off}, 32'h0);
    check("R4 lpbk_mode clear", {31'b0, lpbk_mode}, 32'h0);
    rd(16'h1010, 32'h4, "R4 reserved bit readback");
    wr(16'h1001, 32'h0);
    rd(16'h1001, 32'h434C4E54, "R9 id write ignored");
    wr(16'h1002, 32'h0);
    rd(16'h1002, {22'b0, 1'b1, 1'b0, P_LF, P_PAUSE, P_PTP, P_CAUI, P_KR4, P_REF, P_100G, P_FAM}, "R9 feature write ignored");
    wr(16'h1003, 32'h12345678);
    rd(16'h1003, 32'h0, "R9 unmapped");
    rd(16'h2000, 32'h0, "R9 far unmapped");
    rd(16'h1000, 32'hFFFF0000, "R9 scratch kept");
    fifo_unf = 1'b1; @(negedge clk); fifo_unf = 1'b0;
    rd(16'h1015, 32'h1, "R5 underflow set");
    rd(16'h1015, 32'h1, "R5 underflow sticky");
    fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
    rd(16'h1015, 32'h3, "R5 overflow set");
    wr(16'h1015, 32'h3);
    rd(16'h1015, 32'h3, "R6 flag bits not writable");
    wr(16'h1015, 32'h0);
    rd(16'h1015, 32'h3, "R6 zero write no clear");
    wr(16'h1015, 32'h4);
    rd(16'h1015, 32'h4, "R6 clear bit visible");
    rd(16'h1015, 32'h0, "R6 self cleared");
    fifo_unf = 1'b1; @(negedge clk); fifo_unf = 1'b0;
    fifo_ovf = 1'b1;
    wr(16'h1015, 32'h4);
    fifo_ovf = 1'b0;
    rd(16'h1015, 32'h6, "R6 pulse beats clear");
    rd(16'h1015, 32'h2, "R6 after collision");
    wr(16'h1016, 32'h1);
    check("R7 lpbk_rst set", {31'b0, lpbk_rst}, 32'h1);
    rd(16'h1016, 32'h1, "R7 lrst readback");
    wr(16'h1016, 32'h0);
    check("R7 lpbk_rst clear", {31'b0, lpbk_rst}, 32'h0);
    @(negedge clk);
    check("R10 idle zero", rd_data, 32'h0);
    addr = 16'h1000; wr_data = 32'h11112222; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(32'hFFFF0000); tag_q.push_back("R10 read before write");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd(16'h1000, 32'h11112222, "R1 scratch after collision");
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule